// File: doc/BRIEF.md
# Configuration Data Port Bridge

This block is the data side of an address/data register pair through which a host reaches configuration space behind a bridge. The host first loads a 32-bit configuration address register through a dedicated address-port write. It then issues byte, halfword or word accesses on the data port, and each one becomes a single-cycle request on a downstream configuration bus. That request carries an address, a byte count, write data and a write flag, and its read data returns in the same cycle.

The most significant bit of the address register gates all forwarding. While it is clear, writes are dropped and reads answer with all ones at the access width. While it is set, sub-word accesses fold their two offset bits into the forwarded address, and word accesses forward the register value unchanged. A build-time parameter selects big-endian hosts. In that mode halfword and word data are byte-reversed in both directions.

The host data port takes one access per clock and applies no back-pressure, so an access is accepted in every cycle in which `acc_valid` is high. Each accepted read produces exactly one `rsp_valid` pulse in the following cycle, and writes produce none. The downstream side is a plain pulse with no handshake, so the target must answer reads combinationally in the request cycle.

Top module: `cfgdp_bridge`

## Requirements
- R1: The address register resets to zero, which leaves the port disabled. When `addr_wr_en` is high it loads `addr_wr_data` at the clock edge, and its top bit (bit ADDR_W-1) is the enable.
- R2: A data-port write while the enable bit is 0 raises no `dn_valid` and leaves the downstream target unchanged.
- R3: A read while the enable bit is 0 raises no `dn_valid` and returns all ones at the access width in the next cycle: 0x000000FF for a byte, 0x0000FFFF for a halfword and 0xFFFFFFFF for a word.
- R4: While enabled, an access raises `dn_valid` in the same cycle with `dn_write` equal to `acc_write`, and `dn_valid` is never high without an access.
- R5: For byte (`acc_size`=0) and halfword (`acc_size`=1) accesses, `dn_addr` is the address register ORed with the 2-bit `acc_offset`.
- R6: For word accesses (`acc_size`=2 or 3), `dn_addr` equals the address register and `acc_offset` has no effect.
- R7: `dn_size` is 1 for `acc_size`=0, 2 for `acc_size`=1 and 4 for `acc_size`=2 or 3.
- R8: With BIG_ENDIAN=0, `dn_wdata` is `acc_wdata` with the bits above the access width forced to zero.
- R9: Each accepted read gives `rsp_valid` high exactly one cycle later, with `rsp_rdata` holding the low access-width bits of `dn_rdata` zero-extended to 32 bits. Writes give no `rsp_valid`.
- R10: With BIG_ENDIAN=1, halfword data has its two low bytes exchanged and word data has all four bytes reversed, both on writes before forwarding and on reads after return. Byte data is never reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_wr_en | input | 1 | Address-port write strobe |
| addr_wr_data | input | ADDR_W | Value loaded into the address register |
| acc_valid | input | 1 | Data-port access present this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| acc_offset | input | 2 | Low data-port offset bits |
| acc_wdata | input | 32 | Host write data, low lanes used for sub-word |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_rdata | output | 32 | Read response data, zero-extended |
| dn_valid | output | 1 | Downstream request pulse |
| dn_write | output | 1 | Downstream request is a write |
| dn_addr | output | ADDR_W | Downstream configuration address |
| dn_size | output | 3 | Downstream byte count: 1, 2 or 4 |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid in the request cycle |

## Verification
The bench builds two copies side by side with the default ADDR_W of 32, one with BIG_ENDIAN=0 and one with BIG_ENDIAN=1. Both copies receive identical stimulus, and each has its own byte-array model of configuration space. Because the same writes then leave mirrored byte layouts, the sub-word reads expose both lane orders and the masking of unused lanes. The full address width lets the bench load an address with high bits set, which shows that only the two low bits take part in offset merging and that the enable bit travels through with the address.

// File: rtl/cfgdp_pkg.sv
`timescale 1ns/1ps
package cfgdp_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFS_W  = 2;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'd0,
    SZ_HALF     = 2'd1,
    SZ_WORD     = 2'd2,
    SZ_WORD_ALT = 2'd3
  } acc_size_e;

  // Mask of the lanes that an access of the given width occupies.
  function automatic logic [WORD_W-1:0] width_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    width_mask = 32'h0000_00FF;
      2'd1:    width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // Byte count carried on the downstream bus.
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // Reverse the bytes inside the active width; a single byte stays as is.
  function automatic logic [WORD_W-1:0] lane_swap(input logic [1:0] sz,
                                                  input logic [WORD_W-1:0] d);
    case (sz)
      2'd0:    lane_swap = d;
      2'd1:    lane_swap = {16'h0000, d[7:0], d[15:8]};
      default: lane_swap = {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction
endpackage

// File: rtl/cfgdp_addr_reg.sv
`timescale 1ns/1ps
module cfgdp_addr_reg #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic              enabled
);
  localparam int unsigned EN_BIT = ADDR_W - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_en) addr_q <= wr_data;
  end

  assign enabled = addr_q[EN_BIT];

  assert_wr_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (addr_q == $past(wr_data)));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(addr_q));
endmodule

// File: rtl/cfgdp_lane_swap.sv
`timescale 1ns/1ps
module cfgdp_lane_swap
  import cfgdp_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [1:0]        sz,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  generate
    if (BIG_ENDIAN) begin : g_swap
      assign dout = lane_swap(sz, din);
    end else begin : g_pass
      assign dout = din;
    end
  endgenerate

  // Single bytes must leave this stage untouched in either build.
  always_comb begin
    if (sz == SZ_BYTE)
      assert_byte_unswapped_R10: assert (dout == din);
  end
endmodule

// File: rtl/cfgdp_req_gen.sv
`timescale 1ns/1ps
module cfgdp_req_gen
  import cfgdp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic [OFS_W-1:0]  acc_offset,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              enabled,
  input  logic [WORD_W-1:0] wdata_lane,
  output logic              dn_valid,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [2:0]        dn_size,
  output logic [WORD_W-1:0] dn_wdata
);
  logic               is_word;
  logic [ADDR_W-1:0]  ofs_ext;

  assign is_word = acc_size[1];
  assign ofs_ext = {{(ADDR_W-OFS_W){1'b0}}, acc_offset};

  always_comb begin
    dn_valid = acc_valid & enabled;
    dn_write = acc_write;
    dn_size  = size_bytes(acc_size);
    dn_wdata = wdata_lane;
    dn_addr  = is_word ? addr_q : (addr_q | ofs_ext);
  end
endmodule

// File: rtl/cfgdp_resp.sv
`timescale 1ns/1ps
module cfgdp_resp
  import cfgdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic              enabled,
  input  logic [WORD_W-1:0] rd_lane,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata
);
  logic rd_take;
  assign rd_take = acc_valid & ~acc_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_take;
      if (rd_take)
        rsp_rdata <= enabled ? rd_lane : width_mask(acc_size);
    end
  end

  assert_one_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> rsp_valid);
  assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_take |=> !rsp_valid);
endmodule

// File: rtl/cfgdp_bridge.sv
`timescale 1ns/1ps
module cfgdp_bridge
  import cfgdp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter bit          BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr_en,
  input  logic [ADDR_W-1:0] addr_wr_data,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic [1:0]        acc_offset,
  input  logic [31:0]       acc_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              dn_valid,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [2:0]        dn_size,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic              acc_en;
  logic [WORD_W-1:0] wr_masked, wr_lane;
  logic [WORD_W-1:0] rd_masked, rd_lane;

  cfgdp_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr_en(addr_wr_en), .wr_data(addr_wr_data),
    .addr_q(addr_q), .enabled(acc_en)
  );

  assign wr_masked = acc_wdata & width_mask(acc_size);
  assign rd_masked = dn_rdata  & width_mask(acc_size);

  cfgdp_lane_swap #(.BIG_ENDIAN(BIG_ENDIAN)) u_wr_swap (
    .sz(acc_size), .din(wr_masked), .dout(wr_lane)
  );
  cfgdp_lane_swap #(.BIG_ENDIAN(BIG_ENDIAN)) u_rd_swap (
    .sz(acc_size), .din(rd_masked), .dout(rd_lane)
  );

  cfgdp_req_gen #(.ADDR_W(ADDR_W)) u_req (
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size),
    .acc_offset(acc_offset), .addr_q(addr_q), .enabled(acc_en),
    .wdata_lane(wr_lane), .dn_valid(dn_valid), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_size(dn_size), .dn_wdata(dn_wdata)
  );

  cfgdp_resp u_resp (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .enabled(acc_en), .rd_lane(rd_lane),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_en) |-> !dn_valid);
  assert_disabled_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !acc_en) |=>
      (rsp_valid && rsp_rdata == width_mask($past(acc_size))));
  assert_req_follows_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (acc_valid && dn_write == acc_write));
  assert_subword_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !acc_size[1]) |->
      (dn_addr[ADDR_W-1:2] == addr_q[ADDR_W-1:2] &&
       dn_addr[1:0] == (addr_q[1:0] | acc_offset)));
  assert_word_no_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && acc_size[1]) |-> (dn_addr == addr_q));
  assert_size_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> ($countones(dn_size) == 1));
  assert_byte_zero_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_size == SZ_BYTE) |=> (rsp_rdata[31:8] == 24'h0));
endmodule

// File: tb/cfgdp_bridge_tb.sv
`timescale 1ns/1ps
module cfgdp_bridge_tb_top;
  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [1:0]  off;
    logic [31:0] data;
    logic [31:0] exp_le;
    logic [31:0] exp_be;
  } vec_t;

  localparam int NV = 13;
  localparam logic [31:0] BASE = 32'h8000_0010;
  // For writes exp_* is the expected downstream write data, for reads the response.
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 2'd0, 32'h1122_3344, 32'h1122_3344, 32'h4433_2211},
    '{1'b0, 2'd0, 2'd0, 32'h0,         32'h0000_0044, 32'h0000_0011},
    '{1'b0, 2'd0, 2'd3, 32'h0,         32'h0000_0011, 32'h0000_0044},
    '{1'b0, 2'd1, 2'd0, 32'h0,         32'h0000_3344, 32'h0000_1122},
    '{1'b0, 2'd1, 2'd2, 32'h0,         32'h0000_1122, 32'h0000_3344},
    '{1'b1, 2'd0, 2'd1, 32'h0000_00AA, 32'h0000_00AA, 32'h0000_00AA},
    '{1'b0, 2'd2, 2'd3, 32'h0,         32'h1122_AA44, 32'h11AA_3344},
    '{1'b1, 2'd1, 2'd2, 32'h1234_BEEF, 32'h0000_BEEF, 32'h0000_EFBE},
    '{1'b0, 2'd2, 2'd0, 32'h0,         32'hBEEF_AA44, 32'h11AA_BEEF},
    '{1'b0, 2'd0, 2'd2, 32'h0,         32'h0000_00EF, 32'h0000_00BE},
    '{1'b0, 2'd1, 2'd1, 32'h0,         32'h0000_EFAA, 32'h0000_AABE},
    '{1'b1, 2'd0, 2'd0, 32'hFFFF_FF5A, 32'h0000_005A, 32'h0000_005A},
    '{1'b0, 2'd3, 2'd2, 32'h0,         32'hBEEF_AA5A, 32'h5AAA_BEEF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        addr_wr_en = 1'b0;
  logic [31:0] addr_wr_data = '0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_size = '0, acc_offset = '0;
  logic [31:0] acc_wdata = '0;

  logic        rsp_valid_le, rsp_valid_be, dn_valid_le, dn_valid_be;
  logic        dn_write_le, dn_write_be;
  logic [31:0] rsp_rdata_le, rsp_rdata_be, dn_addr_le, dn_addr_be;
  logic [2:0]  dn_size_le, dn_size_be;
  logic [31:0] dn_wdata_le, dn_wdata_be, dn_rdata_le, dn_rdata_be;

  cfgdp_bridge #(.ADDR_W(32), .BIG_ENDIAN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size),
    .acc_offset(acc_offset), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid_le), .rsp_rdata(rsp_rdata_le),
    .dn_valid(dn_valid_le), .dn_write(dn_write_le), .dn_addr(dn_addr_le),
    .dn_size(dn_size_le), .dn_wdata(dn_wdata_le), .dn_rdata(dn_rdata_le));

  cfgdp_bridge #(.ADDR_W(32), .BIG_ENDIAN(1'b1)) dut_be_i (
    .clk(clk), .rst_n(rst_n), .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size),
    .acc_offset(acc_offset), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid_be), .rsp_rdata(rsp_rdata_be),
    .dn_valid(dn_valid_be), .dn_write(dn_write_be), .dn_addr(dn_addr_be),
    .dn_size(dn_size_be), .dn_wdata(dn_wdata_be), .dn_rdata(dn_rdata_be));

  // Byte-array models of configuration space, one per copy.
  logic [7:0] mem_le [64];
  logic [7:0] mem_be [64];
  logic [5:0] a_le, a_be;
  assign a_le = dn_addr_le[5:0];
  assign a_be = dn_addr_be[5:0];
  assign dn_rdata_le = {mem_le[a_le+6'd3], mem_le[a_le+6'd2], mem_le[a_le+6'd1], mem_le[a_le]};
  assign dn_rdata_be = {mem_be[a_be+6'd3], mem_be[a_be+6'd2], mem_be[a_be+6'd1], mem_be[a_be]};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin
        mem_le[i] <= 8'h00;
        mem_be[i] <= 8'h00;
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (dn_valid_le && dn_write_le && k < int'(dn_size_le))
          mem_le[a_le + 6'(k)] <= dn_wdata_le[8*k +: 8];
        if (dn_valid_be && dn_write_be && k < int'(dn_size_be))
          mem_be[a_be + 6'(k)] <= dn_wdata_be[8*k +: 8];
      end
    end
  end

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Captured outputs of the last access.
  logic        c_dv_le, c_dv_be, c_dw_le, c_dw_be, c_rv_le, c_rv_be;
  logic [31:0] c_da_le, c_da_be, c_wd_le, c_wd_be, c_rd_le, c_rd_be;
  logic [2:0]  c_ds_le, c_ds_be;

  task automatic load_addr(input logic [31:0] v);
    @(negedge clk);
    addr_wr_en = 1'b1;
    addr_wr_data = v;
    @(posedge clk);
    #1 addr_wr_en = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic [1:0] off,
                        input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_size = sz; acc_offset = off; acc_wdata = d;
    #1;
    c_dv_le = dn_valid_le; c_dv_be = dn_valid_be;
    c_dw_le = dn_write_le; c_dw_be = dn_write_be;
    c_da_le = dn_addr_le;  c_da_be = dn_addr_be;
    c_ds_le = dn_size_le;  c_ds_be = dn_size_be;
    c_wd_le = dn_wdata_le; c_wd_be = dn_wdata_be;
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
    c_rv_le = rsp_valid_le; c_rv_be = rsp_valid_be;
    c_rd_le = rsp_rdata_le; c_rd_be = rsp_rdata_be;
  endtask

  function automatic logic [31:0] ones_for(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [2:0] bytes_for(input logic [1:0] sz);
    return (sz == 2'd0) ? 3'd1 : (sz == 2'd1) ? 3'd2 : 3'd4;
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    // Reset state (R1)
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "rsp_valid in reset le", {31'b0, rsp_valid_le}, 32'd0);
    chk("R1", "rsp_valid in reset be", {31'b0, rsp_valid_be}, 32'd0);
    chk("R1", "dn_valid in reset", {30'b0, dn_valid_le, dn_valid_be}, 32'd0);
    rst_n = 1'b1;

    // Disabled reads after reset: all ones at width, no request (R1, R3)
    for (int s = 0; s < 3; s++) begin
      access(1'b0, 2'(s), 2'd2, 32'h0);
      chk("R3", "disabled read dn_valid", {30'b0, c_dv_le, c_dv_be}, 32'd0);
      chk("R3", "disabled read data le", c_rd_le, ones_for(2'(s)));
      chk("R3", "disabled read data be", c_rd_be, ones_for(2'(s)));
      chk("R9", "disabled read rsp_valid", {30'b0, c_rv_le, c_rv_be}, 32'd3);
    end

    // Disabled write is dropped (R2)
    access(1'b1, 2'd2, 2'd0, 32'hDEAD_BEEF);
    chk("R2", "disabled write dn_valid", {30'b0, c_dv_le, c_dv_be}, 32'd0);
    load_addr(BASE);
    access(1'b0, 2'd2, 2'd0, 32'h0);
    chk("R2", "target untouched le", c_rd_le, 32'h0);
    chk("R2", "target untouched be", c_rd_be, 32'h0);

    // Vector table (R4..R10)
    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      logic [31:0] ea = t.sz[1] ? BASE : (BASE | {30'b0, t.off});
      access(t.wr, t.sz, t.off, t.data);
      chk("R4", $sformatf("v%0d dn_valid", v), {30'b0, c_dv_le, c_dv_be}, 32'd3);
      chk("R4", $sformatf("v%0d dn_write", v), {30'b0, c_dw_le, c_dw_be}, {30'b0, t.wr, t.wr});
      chk(t.sz[1] ? "R6" : "R5", $sformatf("v%0d dn_addr le", v), c_da_le, ea);
      chk(t.sz[1] ? "R6" : "R5", $sformatf("v%0d dn_addr be", v), c_da_be, ea);
      chk("R7", $sformatf("v%0d dn_size", v), {26'b0, c_ds_le, c_ds_be},
          {26'b0, bytes_for(t.sz), bytes_for(t.sz)});
      if (t.wr) begin
        chk("R8", $sformatf("v%0d dn_wdata le", v), c_wd_le, t.exp_le);
        chk("R10", $sformatf("v%0d dn_wdata be", v), c_wd_be, t.exp_be);
        chk("R9", $sformatf("v%0d no rsp on write", v), {30'b0, c_rv_le, c_rv_be}, 32'd0);
      end else begin
        chk("R9", $sformatf("v%0d rsp_valid", v), {30'b0, c_rv_le, c_rv_be}, 32'd3);
        chk("R9", $sformatf("v%0d rsp le", v), c_rd_le, t.exp_le);
        chk("R10", $sformatf("v%0d rsp be", v), c_rd_be, t.exp_be);
      end
    end

    // High address bits: only the low two bits merge (R5)
    load_addr(32'h80AB_CD24);
    access(1'b0, 2'd0, 2'd3, 32'h0);
    chk("R5", "high-bit merge le", c_da_le, 32'h80AB_CD27);
    chk("R5", "high-bit merge be", c_da_be, 32'h80AB_CD27);

    // Clearing the enable bit disables again (R1, R3)
    load_addr(32'h0000_0010);
    access(1'b0, 2'd2, 2'd0, 32'h0);
    chk("R1", "re-disabled dn_valid", {30'b0, c_dv_le, c_dv_be}, 32'd0);
    chk("R3", "re-disabled word read", c_rd_le, 32'hFFFF_FFFF);

    repeat (2) @(posedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule